// File: doc/BRIEF.md
# GPIO Data Register Block

This block is the software-visible data plane for 32 general-purpose digital I/O lines. A simple 32-bit register bus with per-byte write strobes reaches it. The block holds the output levels, the per-line output enables and a set of sticky event flags. Software can change output lines in several ways. It can write the whole output word. It can write 1s to atomic set, clear or toggle windows, which removes the need for a read-modify-write sequence. It can also store one byte to a per-line alias lane, which changes exactly one line.

The pad input levels pass through a synchronizer chain and can be read back. Edge-detect logic outside the block produces per-line event pulses. The block latches these into flags that stay set until software clears them by writing 1. Reads are combinational: the read data follows the address in the same cycle. Writes take effect at the clock edge that samples them.

Top module: `gpio_regblk`

## Requirements
- R1: After reset, `pad_out`, `pad_oe` and every event flag are zero, and reads of offsets 0x80, 0xD0 and 0xE0 return zero.
- R2: Offset 0x80 reads and writes the full 32-bit output word. A write changes only the byte lanes whose strobe `bus_be[k]` is set, where lane k covers bits 8k+7 to 8k.
- R3: The eight alias words at offsets 0x00, 0x04, … 0x1C each serve four lines. At offset 4·i, byte lane k writes line 4·i+k from bit 8k of the write data when `bus_be[k]` is set. The other seven bits of the byte are ignored. A read returns each line's output bit in bit 8k, with all other bits zero.
- R4: A write to offset 0x90 sets every output bit written as 1 in an enabled byte lane. All other output bits keep their value.
- R5: A write to offset 0xA0 clears every output bit written as 1 in an enabled byte lane. All other output bits keep their value.
- R6: A write to offset 0xB0 inverts every output bit written as 1 in an enabled byte lane. All other output bits keep their value.
- R7: Reads of offsets 0x90, 0xA0 and 0xB0 return the current output word.
- R8: Offset 0xC0 returns `pad_in` after a two-flop synchronizer. A change on `pad_in` becomes readable after the second rising clock edge. Writes to 0xC0 change no state.
- R9: Offset 0xD0 reads and writes the output-enable word, honoring byte strobes. Its value drives `pad_oe`.
- R10: An `evt_pulse` bit held high for one cycle sets its flag, which stays set across idle cycles. Offset 0xE0 reads the flags. A write to 0xE0 clears the flags written as 1 in enabled byte lanes and leaves the other flags unchanged.
- R11: If an event pulse and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R12: Word offsets not listed above, and any address with nonzero bits 1:0, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_be | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is selected |
| pad_in | input | 32 | Asynchronous pad input levels |
| evt_pulse | input | 32 | Per-line event pulses from edge-detect logic |
| pad_out | output | 32 | Output level per line |
| pad_oe | output | 32 | Output enable per line |

## Verification
The bench targets these corner cases:
- Alias stores that carry junk in bits 7:1 of a lane. A design that tested the whole byte instead of bit 0 would drive the line to the wrong level.
- Set, clear and toggle writes whose 1s fall only in disabled byte lanes. A design that ignored `bus_be` would change outputs it must leave alone.
- The synchronizer read. It is sampled before the first edge, after the first edge and after the second edge, so a single-flop or three-flop chain shows the wrong value in one of those windows.
- An event pulse that lands in the same cycle as its own clear. A design that gave the clear priority would lose the event.
- Writes to the input offset and to unmapped offsets. Either write moving `pad_out` or `pad_oe` exposes decode that is too loose.

// File: rtl/gpio_regblk_pkg.sv
// Shared constants, region type and helper functions for the GPIO data block.
// Assumes a byte-addressed 8-bit offset space with 32-bit word accesses.
package gpio_regblk_pkg;

    localparam int LINES   = 32;
    localparam int LANES   = LINES / 8;
    localparam int ALIASES = LINES / LANES;
    localparam int AIW     = $clog2(ALIASES);

    localparam logic [5:0] WA_DATA = 6'h20;
    localparam logic [5:0] WA_SET  = 6'h24;
    localparam logic [5:0] WA_CLR  = 6'h28;
    localparam logic [5:0] WA_TGL  = 6'h2C;
    localparam logic [5:0] WA_IN   = 6'h30;
    localparam logic [5:0] WA_OE   = 6'h34;
    localparam logic [5:0] WA_EVT  = 6'h38;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ALIAS,
        RG_DATA,
        RG_SET,
        RG_CLR,
        RG_TGL,
        RG_IN,
        RG_OE,
        RG_EVT
    } rgn_e;

    // Map a byte address to the register region it selects.
    function automatic rgn_e decode_rgn(input logic [7:0] addr);
        logic [5:0] wa;
        rgn_e r;
        wa = addr[7:2];
        r  = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (wa < 6'(ALIASES)) begin
                r = RG_ALIAS;
            end else begin
                case (wa)
                    WA_DATA: r = RG_DATA;
                    WA_SET:  r = RG_SET;
                    WA_CLR:  r = RG_CLR;
                    WA_TGL:  r = RG_TGL;
                    WA_IN:   r = RG_IN;
                    WA_OE:   r = RG_OE;
                    WA_EVT:  r = RG_EVT;
                    default: r = RG_NONE;
                endcase
            end
        end
        return r;
    endfunction

    // Expand byte strobes into a per-bit write mask.
    function automatic logic [LINES-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [LINES-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the pad input bus.
// Assumes each bit is sampled independently (no bus coherence is implied).
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= async_in;
            end
        end else begin : g_next
            // Later stages shift the level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_ctl.sv
// Output data and output enable registers with whole-word, set, clear,
// toggle and per-line alias write paths.
// Assumes the caller has already decoded the region and qualified wr_en.
module gpio_out_ctl
    import gpio_regblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rgn_e             rgn,
    input  logic [AIW-1:0]   alias_idx,
    input  logic [LANES-1:0] be,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] dout,
    output logic [LINES-1:0] doe
);

    logic [LINES-1:0] bmask;
    logic [LINES-1:0] wbits;
    logic [LINES-1:0] dout_nx;
    logic [LINES-1:0] doe_nx;

    assign bmask = lane_mask(be);
    assign wbits = wdata & bmask;

    // Next output word for each write flavour.
    always_comb begin
        dout_nx = dout;
        if (wr_en) begin
            case (rgn)
                RG_DATA: dout_nx = (dout & ~bmask) | wbits;
                RG_SET:  dout_nx = dout | wbits;
                RG_CLR:  dout_nx = dout & ~wbits;
                RG_TGL:  dout_nx = dout ^ wbits;
                RG_ALIAS: begin
                    for (int j = 0; j < LINES; j++) begin
                        if ((int'(alias_idx) == (j / LANES)) && be[j % LANES]) begin
                            dout_nx[j] = wdata[8 * (j % LANES)];
                        end
                    end
                end
                default: dout_nx = dout;
            endcase
        end
    end

    // Next output enable word.
    always_comb begin
        doe_nx = doe;
        if (wr_en && rgn == RG_OE) begin
            doe_nx = (doe & ~bmask) | wbits;
        end
    end

    // Register both words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            doe  <= '0;
        end else begin
            dout <= dout_nx;
            doe  <= doe_nx;
        end
    end

endmodule

// File: rtl/gpio_evt_latch.sv
// Sticky per-line event flags, set by hardware pulses, cleared by writing 1.
// Assumes a pulse has priority over a clear arriving in the same cycle.
module gpio_evt_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] evt,
    output logic [W-1:0] flags
);

    logic [W-1:0] keep;

    assign keep = clr_en ? (flags & ~clr_bits) : flags;

    // Clear first, then OR in this cycle's pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= keep | evt;
    end

endmodule

// File: rtl/gpio_regblk.sv
// Top of the GPIO data register block: bus decode, read mux and the
// output, input and event submodules.
// Assumes single-cycle bus accesses; reads are combinational.
module gpio_regblk
    import gpio_regblk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pad_in,
    input  logic [31:0] evt_pulse,
    output logic [31:0] pad_out,
    output logic [31:0] pad_oe
);

    rgn_e             rgn;
    logic [AIW-1:0]   alias_idx;
    logic             wr_en;
    logic             rd_en;
    logic [LINES-1:0] dout_q;
    logic [LINES-1:0] doe_q;
    logic [LINES-1:0] din_sync;
    logic [LINES-1:0] evt_flags_q;

    assign rgn       = decode_rgn(bus_addr);
    assign alias_idx = bus_addr[AIW+1:2];
    assign wr_en     = bus_sel & bus_wr;
    assign rd_en     = bus_sel & ~bus_wr;

    gpio_out_ctl u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rgn       (rgn),
        .alias_idx (alias_idx),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .dout      (dout_q),
        .doe       (doe_q)
    );

    gpio_in_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_evt_latch #(
        .W (LINES)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_en && (rgn == RG_EVT)),
        .clr_bits (bus_wdata & lane_mask(bus_be)),
        .evt      (evt_pulse),
        .flags    (evt_flags_q)
    );

    // Select read data by region; alias words spread lines onto bit 0 of each lane.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (rgn)
                RG_DATA, RG_SET, RG_CLR, RG_TGL: bus_rdata = dout_q;
                RG_IN:  bus_rdata = din_sync;
                RG_OE:  bus_rdata = doe_q;
                RG_EVT: bus_rdata = evt_flags_q;
                RG_ALIAS: begin
                    for (int j = 0; j < LINES; j++) begin
                        if (int'(alias_idx) == (j / LANES)) begin
                            bus_rdata[8 * (j % LANES)] = dout_q[j];
                        end
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = dout_q;
    assign pad_oe  = doe_q;

endmodule

// File: rtl/gpio_regblk_chk.sv
// Property checker for gpio_regblk, attached with bind.
// Assumes it observes the top-level ports plus the event flag state.
module gpio_regblk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] pad_out,
    input logic [31:0] pad_oe,
    input logic [31:0] evt_pulse,
    input logic [31:0] evt_flags
);

    logic [5:0]  wa;
    logic [31:0] wm;
    logic        mapped;
    logic        wr;

    assign wa = bus_addr[7:2];
    assign wr = bus_sel && bus_wr;
    assign wm = bus_wdata & {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
    assign mapped = (bus_addr[1:0] == 2'b00) &&
                    ((wa < 6'd8) || (wa == 6'h20) || (wa == 6'h24) || (wa == 6'h28) ||
                     (wa == 6'h2C) || (wa == 6'h30) || (wa == 6'h34) || (wa == 6'h38));

    // R4: set window raises written bits and holds the rest.
    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'h90) |=> pad_out == ($past(pad_out) | $past(wm)));

    // R5: clear window lowers written bits and holds the rest.
    a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'hA0) |=> pad_out == ($past(pad_out) & ~$past(wm)));

    // R6: toggle window inverts written bits only.
    a_r6_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'hB0) |=> pad_out == ($past(pad_out) ^ $past(wm)));

    // R8: writes to the input offset touch no output state.
    a_r8_in_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 8'hC0) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R10: without a clear write, no flag ever falls.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && bus_addr == 8'hE0) |=> (($past(evt_flags) & ~evt_flags) == 32'h0));

    // R11: every pulsed line has its flag set on the next cycle.
    a_r11_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != 32'h0) |=> ((evt_flags & $past(evt_pulse)) == $past(evt_pulse)));

    // R12: unmapped reads return zero.
    a_r12_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == 32'h0));

    // R12: unmapped writes leave outputs alone.
    a_r12_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind gpio_regblk gpio_regblk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .evt_pulse (evt_pulse),
    .evt_flags (evt_flags_q)
);

// File: tb/gpio_regblk_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: bus_read pushes expected words, a negedge monitor compares.
module gpio_regblk_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] evt_pulse;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [31:0] m_dout;
    logic [31:0] m_doe;
    logic [31:0] m_flags;

    always #5 clk = ~clk;

    gpio_regblk dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .evt_pulse (evt_pulse),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read against the scoreboard head.
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] alias_view(input int idx);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) r[8*k] = m_dout[4*idx + k];
        return r;
    endfunction

    // Update the reference model from the requirement text.
    task automatic model_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] m;
        int wa;
        m  = bmask(be);
        wa = int'(a[7:2]);
        if (a[1:0] == 2'b00) begin
            if (wa < 8) begin
                for (int k = 0; k < 4; k++) if (be[k]) m_dout[4*wa + k] = d[8*k];
            end else begin
                case (a)
                    8'h80: m_dout  = (m_dout & ~m) | (d & m);
                    8'h90: m_dout  = m_dout | (d & m);
                    8'hA0: m_dout  = m_dout & ~(d & m);
                    8'hB0: m_dout  = m_dout ^ (d & m);
                    8'hD0: m_doe   = (m_doe & ~m) | (d & m);
                    8'hE0: m_flags = m_flags & ~(d & m);
                    default: ;
                endcase
            end
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_write(a, be, d);
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'h0; bus_wdata = '0;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0;
        bus_wdata = '0; pad_in = '0; evt_pulse = '0;
        m_dout = '0; m_doe = '0; m_flags = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state.
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        bus_read(8'h80, 32'h0, "R1 data word");
        bus_read(8'hD0, 32'h0, "R1 enable word");
        bus_read(8'hE0, 32'h0, "R1 flags");

        // R2: full word and strobed byte write.
        bus_write(8'h80, 4'hF, 32'hA5A5_5A5A);
        bus_read(8'h80, m_dout, "R2 full write");
        bus_write(8'h80, 4'b0010, 32'hFFFF_FFFF);
        check("R2 strobed byte", pad_out, 32'hA5A5_FF5A);
        bus_read(8'h80, m_dout, "R2 readback");

        // R3: alias lanes take bit 0 only; reads spread lines to bit 8k.
        bus_write(8'h04, 4'hF, 32'h01FE_01FE);
        check("R3 alias lanes", pad_out, 32'hA5A5_FFAA);
        bus_read(8'h04, 32'h0100_0100, "R3 alias read");
        bus_write(8'h1C, 4'b1000, 32'h0000_0001);
        check("R3 single lane", pad_out, 32'h25A5_FFAA);
        bus_read(8'h1C, alias_view(7), "R3 alias read top");
        bus_read(8'h00, alias_view(0), "R3 alias read bottom");

        // R4, R5, R6: atomic windows with strobes.
        bus_write(8'h90, 4'hF, 32'h0000_000F);
        check("R4 set", pad_out, m_dout);
        bus_write(8'hA0, 4'hF, 32'hF000_0000);
        check("R5 clear", pad_out, m_dout);
        bus_write(8'hB0, 4'b0011, 32'hFFFF_0000);
        check("R6 toggle masked lanes", pad_out, m_dout);
        bus_write(8'hB0, 4'hF, 32'h0F0F_0F0F);
        check("R6 toggle", pad_out, m_dout);
        bus_write(8'h90, 4'b1100, 32'h0000_FFFF);
        check("R4 set masked lanes", pad_out, m_dout);

        // R7: window reads mirror the data word.
        bus_read(8'h90, m_dout, "R7 set window read");
        bus_read(8'hA0, m_dout, "R7 clear window read");
        bus_read(8'hB0, m_dout, "R7 toggle window read");

        // R9: output enable.
        bus_write(8'hD0, 4'hF, 32'h1234_5678);
        check("R9 pad_oe", pad_oe, 32'h1234_5678);
        bus_write(8'hD0, 4'b0100, 32'h00FF_0000);
        check("R9 strobed oe", pad_oe, 32'h12FF_5678);
        bus_read(8'hD0, m_doe, "R9 readback");

        // R8: two-stage synchronizer and read-only input.
        pad_in = 32'hDEAD_BEEF;
        bus_read(8'hC0, 32'h0, "R8 before first edge");
        bus_read(8'hC0, 32'h0, "R8 after one edge");
        bus_read(8'hC0, 32'hDEAD_BEEF, "R8 after two edges");
        bus_write(8'hC0, 4'hF, 32'h0000_0000);
        check("R8 write ignored out", pad_out, m_dout);
        check("R8 write ignored oe", pad_oe, m_doe);
        bus_read(8'hC0, 32'hDEAD_BEEF, "R8 input unchanged");

        // R10: event latching and write-1-to-clear.
        evt_pulse = 32'h0000_0028;
        @(posedge clk); #1;
        evt_pulse = '0;
        m_flags = m_flags | 32'h0000_0028;
        repeat (3) @(posedge clk);
        #1;
        bus_read(8'hE0, 32'h0000_0028, "R10 sticky flags");
        bus_write(8'hE0, 4'hF, 32'h0000_0008);
        bus_read(8'hE0, 32'h0000_0020, "R10 clear one flag");
        bus_write(8'hE0, 4'b1110, 32'h0000_0020);
        bus_read(8'hE0, 32'h0000_0020, "R10 clear masked lane");

        // R11: pulse and clear on the same bit in one cycle.
        evt_pulse = 32'h0000_0220;
        bus_write(8'hE0, 4'hF, 32'h0000_0220);
        evt_pulse = '0;
        m_flags = m_flags | 32'h0000_0220;
        bus_read(8'hE0, 32'h0000_0220, "R11 pulse beats clear");

        // R12: unmapped offsets.
        bus_read(8'h40, 32'h0, "R12 unmapped read");
        bus_read(8'hFC, 32'h0, "R12 top offset read");
        bus_read(8'h82, 32'h0, "R12 misaligned read");
        bus_write(8'h40, 4'hF, 32'hFFFF_FFFF);
        bus_write(8'h81, 4'hF, 32'hFFFF_FFFF);
        check("R12 write ignored out", pad_out, m_dout);
        check("R12 write ignored oe", pad_oe, m_doe);
        bus_read(8'h80, m_dout, "R12 data intact");

        repeat (2) @(posedge clk);
        finish_up();
    end

endmodule